// File: doc/BRIEF.md
# Ring-Buffer DMA Write Address Wrapper

This block sits on the write side of a DMA path that deposits quadword bursts into a ring buffer held in main memory. For every burst it is told the start address and the length in quadwords. It returns the destination address that follows the burst. In ring mode, that address is folded back into the ring. The block also flags bursts whose start address falls outside the ring.

The ring is described by a base address and a size mask. Wrapping is done by masking, not by comparing and subtracting. The quadwords that land inside the ring are summed in a saturating counter. When the source channel reaches its service point, the sum is handed to the drain channel that the mode selects, and the counter is cleared. If the selected drain is still busy at that moment, the source channel's completion interrupt is held back.

Top module: `ringdma_wrap`

## Requirements
- R1: After reset, `addr_valid`, `outside`, `cnt_valid` and `irq` are 0, `next_addr` is 0 and the quadword counter is 0.
- R2: `mode` is encoded as follows: 0 means no drain, 1 is reserved, 2 drains to consumer 0, and 3 drains to consumer 1. In modes 0 and 1, a burst gives `next_addr = start + len*16` with no wrap, and `outside` stays 0. Such bursts are never counted.
- R3: In modes 2 and 3, a burst gives `next_addr = base + ((start + len*16) AND mask)`. The result appears with `addr_valid = 1` in the cycle after `burst_valid`.
- R4: In modes 2 and 3, `outside` is 1 with the result when `(start AND NOT mask) != base`. The address is still wrapped, and the burst length is not counted.
- R5: In modes 2 and 3, the lengths of in-ring bursts accumulate across bursts until a service point forwards them.
- R6: The counter is 16 bits wide and saturates at 65535 instead of wrapping.
- R7: A `service` pulse in mode 2 or 3 with a nonzero total gives a one-cycle `cnt_valid` in the next cycle. The total includes a burst in the same cycle. It is reported on `cnt_value`, with `cnt_target` equal to `mode` bit 0 (0 means consumer 0, 1 means consumer 1). The counter then restarts from 0.
- R8: A `service` pulse raises `irq` for one cycle in the next cycle. The exception is when a count is forwarded and the selected drain's busy input (`drain0_busy` for target 0, `drain1_busy` for target 1) is 1 in the service cycle; then `irq` stays 0.
- R9: A `service` pulse with a zero total forwards nothing (`cnt_valid` stays 0) and keeps the counter unchanged. In modes 0 and 1, `service` also forwards nothing and leaves any pending count in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Drain select (0 none, 1 reserved, 2 consumer 0, 3 consumer 1) |
| ring_base | input | 32 | Ring base address, aligned to the mask |
| ring_mask | input | 32 | Ring size mask, low 4 bits clear |
| burst_valid | input | 1 | A burst is presented this cycle |
| burst_addr | input | 32 | Burst start address |
| burst_len | input | 16 | Burst length in quadwords |
| service | input | 1 | Source channel service point |
| drain0_busy | input | 1 | Consumer 0 still running |
| drain1_busy | input | 1 | Consumer 1 still running |
| next_addr | output | 32 | Address following the last burst |
| addr_valid | output | 1 | `next_addr` and `outside` were updated this cycle |
| outside | output | 1 | The last burst started outside the ring |
| cnt_valid | output | 1 | Count pulse to the drain |
| cnt_value | output | 16 | Forwarded quadword count |
| cnt_target | output | 1 | Drain receiving the count |
| irq | output | 1 | Source channel completion interrupt |

## Verification
The wrap check assumes that `ring_base` has no bits set under `ring_mask` and that the mask's low 4 bits are clear. Under those conditions, every ring-mode result lands inside the ring. The bench builds each random mask as a run of low ones with the bottom nibble cleared, and it builds the base by clearing the mask bits from a random word. Start addresses are drawn either inside the ring or anywhere at all. This exercises both the flagged and the unflagged path while the register setup stays legal.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 16;
    localparam int CNT_W    = 16;
    localparam int QW_SHIFT = 4;

    typedef enum logic [1:0] {
        DRN_NONE  = 2'd0,
        DRN_RSVD  = 2'd1,
        DRN_CONS0 = 2'd2,
        DRN_CONS1 = 2'd3
    } drain_mode_e;

    function automatic logic mode_is_ring(drain_mode_e m);
        return (m == DRN_CONS0) || (m == DRN_CONS1);
    endfunction

    function automatic logic mode_target(drain_mode_e m);
        return (m == DRN_CONS1);
    endfunction

endpackage

// File: rtl/ringdma_addr.sv
module ringdma_addr
    import ringdma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  drain_mode_e   mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic          bvalid,
    input  logic [AW-1:0] baddr,
    input  logic [LW-1:0] blen,
    output logic          count_en,
    output logic [AW-1:0] next_addr,
    output logic          addr_valid,
    output logic          outside
);

    logic          ring;
    logic [AW-1:0] byte_len;
    logic [AW-1:0] linear;
    logic [AW-1:0] wrapped;
    logic          miss;

    always_comb begin
        ring     = mode_is_ring(mode);
        byte_len = AW'(blen) << QW_SHIFT;
        linear   = baddr + byte_len;
        wrapped  = base + (linear & mask);
        miss     = ring && ((baddr & ~mask) != base);
        count_en = bvalid && ring && !miss;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_addr  <= '0;
            addr_valid <= 1'b0;
            outside    <= 1'b0;
        end else begin
            addr_valid <= bvalid;
            outside    <= bvalid && miss;
            if (bvalid)
                next_addr <= ring ? wrapped : linear;
        end
    end

    // R4: the flag only appears for ring-mode bursts
    a_r4_flag_ring_only: assert property (@(posedge clk) disable iff (rst)
        outside |-> (addr_valid && mode_is_ring(drain_mode_e'($past(mode)))));

    // R3: a wrapped result stays inside the ring (base aligned to mask)
    a_r3_in_ring: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && mode_is_ring(drain_mode_e'($past(mode))) &&
         (($past(base) & $past(mask)) == '0))
        |-> ((next_addr & ~$past(mask)) == $past(base)));

    // R2: no flag in the non-drain modes
    a_r2_linear_noflag: assert property (@(posedge clk) disable iff (rst)
        ($past(bvalid) && !mode_is_ring(drain_mode_e'($past(mode)))) |-> !outside);

endmodule

// File: rtl/ringdma_count.sv
module ringdma_count
    import ringdma_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  drain_mode_e   mode,
    input  logic          add_en,
    input  logic [LW-1:0] add_len,
    input  logic          service,
    input  logic          busy0,
    input  logic          busy1,
    output logic          cnt_valid,
    output logic [CW-1:0] cnt_value,
    output logic          cnt_target,
    output logic          irq
);

    localparam int SW = ((CW > LW) ? CW : LW) + 1;
    localparam logic [SW-1:0] CMAX = SW'({CW{1'b1}});

    logic [CW-1:0] acc;
    logic [SW-1:0] sum;
    logic [CW-1:0] total;
    logic          fwd;
    logic          busy_sel;

    always_comb begin
        sum      = SW'(acc) + (add_en ? SW'(add_len) : '0);
        total    = (sum > CMAX) ? CMAX[CW-1:0] : sum[CW-1:0];
        fwd      = service && mode_is_ring(mode) && (total != '0);
        busy_sel = mode_target(mode) ? busy1 : busy0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            cnt_valid  <= 1'b0;
            cnt_value  <= '0;
            cnt_target <= 1'b0;
            irq        <= 1'b0;
        end else begin
            acc       <= fwd ? '0 : total;
            cnt_valid <= fwd;
            irq       <= service && !(fwd && busy_sel);
            if (fwd) begin
                cnt_value  <= total;
                cnt_target <= mode_target(mode);
            end
        end
    end

    // R6: the counter never wraps downward except when it is forwarded
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !$past(fwd) |-> (acc >= $past(acc)));

    // R7: after a forward the counter restarts from zero
    a_r7_clear_after_send: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |-> (acc == '0));

    // R9: a forwarded count is never zero
    a_r9_nonzero_pulse: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |-> (cnt_value != '0));

    // R8: interrupt withheld while the selected drain is busy
    a_r8_irq_withheld: assert property (@(posedge clk) disable iff (rst)
        (cnt_valid && $past(busy_sel)) |-> !irq);

endmodule

// File: rtl/ringdma_wrap.sv
module ringdma_wrap
    import ringdma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] ring_base,
    input  logic [AW-1:0] ring_mask,
    input  logic          burst_valid,
    input  logic [AW-1:0] burst_addr,
    input  logic [LW-1:0] burst_len,
    input  logic          service,
    input  logic          drain0_busy,
    input  logic          drain1_busy,
    output logic [AW-1:0] next_addr,
    output logic          addr_valid,
    output logic          outside,
    output logic          cnt_valid,
    output logic [CW-1:0] cnt_value,
    output logic          cnt_target,
    output logic          irq
);

    drain_mode_e mode_e;
    logic        count_en;

    assign mode_e = drain_mode_e'(mode);

    ringdma_addr #(.AW(AW), .LW(LW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .base       (ring_base),
        .mask       (ring_mask),
        .bvalid     (burst_valid),
        .baddr      (burst_addr),
        .blen       (burst_len),
        .count_en   (count_en),
        .next_addr  (next_addr),
        .addr_valid (addr_valid),
        .outside    (outside)
    );

    ringdma_count #(.CW(CW), .LW(LW)) u_count (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .add_en     (count_en),
        .add_len    (burst_len),
        .service    (service),
        .busy0      (drain0_busy),
        .busy1      (drain1_busy),
        .cnt_valid  (cnt_valid),
        .cnt_value  (cnt_value),
        .cnt_target (cnt_target),
        .irq        (irq)
    );

    // R7: count pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |=> !cnt_valid || $past(service));

endmodule

// File: tb/test_ringdma_wrap.sv
module test_ringdma_wrap;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [31:0] ring_base, ring_mask;
    logic        burst_valid;
    logic [31:0] burst_addr;
    logic [15:0] burst_len;
    logic        service, drain0_busy, drain1_busy;
    logic [31:0] next_addr;
    logic        addr_valid, outside, cnt_valid, cnt_target, irq;
    logic [15:0] cnt_value;

    int checks = 0;
    int errors = 0;
    int model_acc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ringdma_wrap i_ringdma_wrap (
        .clk(clk), .rst(rst), .mode(mode), .ring_base(ring_base), .ring_mask(ring_mask),
        .burst_valid(burst_valid), .burst_addr(burst_addr), .burst_len(burst_len),
        .service(service), .drain0_busy(drain0_busy), .drain1_busy(drain1_busy),
        .next_addr(next_addr), .addr_valid(addr_valid), .outside(outside),
        .cnt_valid(cnt_valid), .cnt_value(cnt_value), .cnt_target(cnt_target), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] a, input logic [15:0] q);
        logic [31:0] lin;
        lin = a + {12'd0, q, 4'd0};
        return m[1] ? ring_base + (lin & ring_mask) : lin;
    endfunction

    function automatic logic exp_outside(input logic [1:0] m, input logic [31:0] a);
        return m[1] && ((a & ~ring_mask) != ring_base);
    endfunction

    task automatic step(input logic bv, input logic [31:0] a, input logic [15:0] q,
                        input logic sv, input logic [1:0] m, input logic b0, input logic b1);
        logic e_out, e_fwd, e_irq, add;
        logic [31:0] e_addr;
        int tot;
        bit sat;
        @(negedge clk);
        burst_valid = bv; burst_addr = a; burst_len = q;
        service = sv; mode = m; drain0_busy = b0; drain1_busy = b1;
        e_addr = exp_addr(m, a, q);
        e_out  = exp_outside(m, a);
        add    = bv && m[1] && !e_out;
        tot    = model_acc + (add ? int'(q) : 0);
        sat    = (tot > 65535);
        if (sat) tot = 65535;
        e_fwd  = sv && m[1] && (tot != 0);
        e_irq  = sv && !(e_fwd && (m[0] ? b1 : b0));
        @(posedge clk);
        #1;
        chk("R3", "addr_valid", 32'(addr_valid), 32'(bv));
        if (bv) begin
            chk(m[1] ? "R3" : "R2", "next_addr", next_addr, e_addr);
            chk(m[1] ? "R4" : "R2", "outside", 32'(outside), 32'(e_out));
        end
        chk((sv && m[1] && tot == 0) ? "R9" : "R7", "cnt_valid", 32'(cnt_valid), 32'(e_fwd));
        if (e_fwd) begin
            chk(sat ? "R6" : "R5", "cnt_value", 32'(cnt_value), 32'(tot));
            chk("R7", "cnt_target", 32'(cnt_target), 32'(m[0]));
        end
        chk("R8", "irq", 32'(irq), 32'(e_irq));
        model_acc = e_fwd ? 0 : tot;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; mode = 0; ring_base = 32'h0001_0000; ring_mask = 32'h0000_0FF0;
        burst_valid = 0; burst_addr = 0; burst_len = 0;
        service = 0; drain0_busy = 0; drain1_busy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk("R1", "addr_valid", 32'(addr_valid), 0);
        chk("R1", "outside", 32'(outside), 0);
        chk("R1", "cnt_valid", 32'(cnt_valid), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "next_addr", next_addr, 0);

        // R1 counter starts at zero: first forward equals first burst
        step(1, 32'h0001_0100, 16'd5, 1, 2'd2, 0, 0);
        // R2 linear modes, not counted
        step(1, 32'h0001_0FF0, 16'd4, 0, 2'd0, 0, 0);
        step(1, 32'h0002_0000, 16'd3, 0, 2'd1, 0, 0);
        step(0, 0, 0, 1, 2'd3, 0, 0);        // R9 zero total
        // R3 wrap across the ring end
        step(1, 32'h0001_0FE0, 16'd6, 0, 2'd3, 0, 0);
        // R4 outside start, not counted
        step(1, 32'h0003_0010, 16'd7, 0, 2'd3, 0, 0);
        // R5 accumulate then forward to consumer 1 while busy (R8)
        step(1, 32'h0001_0200, 16'd2, 1, 2'd3, 0, 1);
        // R9 service in mode 0 keeps a pending count
        step(1, 32'h0001_0300, 16'd9, 0, 2'd2, 0, 0);
        step(0, 0, 0, 1, 2'd0, 0, 0);
        step(0, 0, 0, 1, 2'd2, 1, 0);
        // R6 saturation
        step(1, 32'h0001_0000, 16'hFFFF, 0, 2'd2, 0, 0);
        step(1, 32'h0001_0000, 16'hFFFF, 0, 2'd2, 0, 0);
        step(0, 0, 0, 1, 2'd2, 0, 0);
        step(0, 0, 0, 0, 2'd2, 0, 0);

        for (int i = 0; i < 600; i++) begin
            int k;
            logic [31:0] a;
            if (i % 50 == 0) begin
                k = 8 + int'($urandom_range(0, 12));
                ring_mask = ((32'd1 << k) - 1) & ~32'hF;
                ring_base = $urandom() & ~ring_mask;
            end
            a = ($urandom_range(0, 3) != 0) ? (ring_base | ($urandom() & ring_mask)) : $urandom();
            step($urandom_range(0, 3) != 0, a, 16'($urandom_range(0, 400)),
                 $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        finish_run();
    end

endmodule